// File: doc/BRIEF.md
# SDRAM Burst Termination Engine

This block is the device-side burst sequencer of a single-bank synchronous DRAM model. On every rising clock edge it decodes the four command strobes and runs read or write bursts against a small internal cell array, one column per cycle. Read data leaves through a latency pipeline, so it appears two or three cycles after the column is accessed, depending on the programmed CAS latency. When the read data ends, the data output enable drops.

Two burst modes exist. In full-page mode a burst walks the columns of the open row and wraps at the page end. It runs until a burst-stop command, a new read or write, or a precharge ends it. In fixed mode a burst is four beats long, and a burst stop counts as an illegal command. Mode-register loading is reduced to the latency and full-page inputs. A read or write with no open row is reported and dropped.

Top module: `sdram_burst_term`

## Requirements
- R1: Commands are decoded from (cs_n, ras_n, cas_n, we_n) at each rising edge: activate 0011, read 0101, write 0100, precharge 0010, burst stop 0110, and nop 0111 or cs_n high. Activate opens row addr_i[1:0]. Read and write take column addr_i[2:0].
- R2: A read burst whose first column is accessed at edge E presents beat k on dq_o, with dq_oe_o high, in the cycle that ends at edge E+CL+k. CL is cas_lat_i, either 2 or 3.
- R3: A full-page burst accesses one column per edge and wraps from column 7 to column 0. It keeps going until it is terminated.
- R4: A full-page read stopped at edge S delivers every beat accessed before S. dq_oe_o is low from the cycle ending at edge S+CL.
- R5: A full-page write stores dq_i at every edge from the write command up to the edge before the stop. dq_i at the stop edge and at later edges is not stored.
- R6: After a burst stop the row stays open, so later reads and writes need no new activate.
- R7: A burst stop with full_page_i low raises illegal_cmd_o for the one cycle after that edge. The running four-beat burst is left unchanged.
- R8: A read that interrupts a read starts at its own column. Old beats already in the pipeline are still delivered, and the new beat 0 follows at its own E+CL with no gap or overlap.
- R9: A precharge ends the burst and closes the row. Read beats accessed before it are still delivered.
- R10: A read or write with no open row raises illegal_cmd_o for one cycle. It drives no data and writes nothing.
- R11: While rst_ni is low, dq_oe_o and illegal_cmd_o are low and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; commands are sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | 3 | Row (activate) or start column (read/write) |
| dq_i | input | 8 | Write data |
| dq_o | output | 8 | Read data |
| dq_oe_o | output | 1 | High while dq_o carries a valid beat |
| cas_lat_i | input | 2 | Read latency in cycles, 2 or 3 |
| full_page_i | input | 1 | 1: full-page bursts, 0: four-beat bursts |
| illegal_cmd_o | output | 1 | One-cycle pulse after an illegal command |

## Verification
If the burst-active state or the column counter were wrong, the error would reach dq_o and dq_oe_o CL cycles after the edge where it arose. It would show as a missing, extra or misplaced beat at the end of a stopped burst, or as a wrong value where the page wraps. If the stop or precharge decode were off by one edge, the enable would fall one cycle early or late, and the bench checks that exact cycle at both latencies. Errors in row-open state show up as illegal_cmd_o one cycle after the next read. Write-side errors stay hidden until a later read-back, which compares the stop-edge column against its old value.

// File: rtl/sdram_bt_pkg.sv
`timescale 1ns/1ps
package sdram_bt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_BST,
    CMD_OTHER
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
module sdram_cmd_decode
  import sdram_bt_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_n_i) begin
      cmd_o = CMD_NOP;
    end else begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b110:  cmd_o = CMD_BST;
        3'b111:  cmd_o = CMD_NOP;
        default: cmd_o = CMD_OTHER; // refresh, mode load: not modelled
      endcase
    end
  end
endmodule

// File: rtl/sdram_burst_ctl.sv
`timescale 1ns/1ps
module sdram_burst_ctl
  import sdram_bt_pkg::*;
#(
  parameter int ROW_W     = 2,
  parameter int COL_W     = 3,
  parameter int BURST_LEN = 4,
  localparam int LEFT_W   = $clog2(BURST_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             full_page_i,
  output logic             issue_o,
  output logic             issue_wr_o,
  output logic [COL_W-1:0] issue_col_o,
  output logic             wr_start_o,
  output logic [ROW_W-1:0] row_o,
  output logic             illegal_o
);
  logic              active_q, wr_q, row_open_q, illegal_q;
  logic [COL_W-1:0]  col_q;
  logic [LEFT_W-1:0] left_q;
  logic [ROW_W-1:0]  row_q;

  logic rw_cmd, rw_ok, stop_ok, cont, bad;

  always_comb begin
    rw_cmd      = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
    rw_ok       = rw_cmd && row_open_q;
    stop_ok     = (cmd_i == CMD_BST) && full_page_i;
    cont        = active_q && !rw_cmd && !stop_ok && (cmd_i != CMD_PRE);
    bad         = ((cmd_i == CMD_BST) && !full_page_i) || (rw_cmd && !row_open_q);
    issue_o     = rw_ok || cont;
    issue_wr_o  = rw_ok ? (cmd_i == CMD_WR) : wr_q;
    issue_col_o = rw_ok ? col_i : col_q;
    wr_start_o  = rw_ok && (cmd_i == CMD_WR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      wr_q      <= 1'b0;
      col_q     <= '0;
      left_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= bad;
      if (rw_ok) begin
        active_q <= full_page_i || (BURST_LEN > 1);
        wr_q     <= (cmd_i == CMD_WR);
        col_q    <= col_i + 1'b1;
        left_q   <= LEFT_W'(BURST_LEN - 1);
      end else if (stop_ok || (cmd_i == CMD_PRE)) begin
        active_q <= 1'b0;
      end else if (cont) begin
        col_q <= col_q + 1'b1; // wraps at page end
        if (!full_page_i) begin
          left_q <= left_q - 1'b1;
          if (left_q <= LEFT_W'(1)) active_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_open_q <= 1'b0;
      row_q      <= '0;
    end else if (cmd_i == CMD_ACT) begin
      row_open_q <= 1'b1;
      row_q      <= row_i;
    end else if (cmd_i == CMD_PRE) begin
      row_open_q <= 1'b0;
    end
  end

  assign row_o     = row_q;
  assign illegal_o = illegal_q;

  assert_bst_keeps_row_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_BST && row_open_q) |=> row_open_q);
  assert_bad_bst_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_BST && !full_page_i) |=> illegal_o);
  assert_bad_bst_noeffect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_BST && !full_page_i && active_q && left_q > LEFT_W'(1)) |=> active_q);
  assert_pre_closes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PRE) |=> (!row_open_q && !active_q));
  assert_norow_dropped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rw_cmd && !row_open_q) |-> !issue_o);
endmodule

// File: rtl/sdram_read_pipe.sv
`timescale 1ns/1ps
module sdram_read_pipe #(
  parameter int DATA_W = 8,
  parameter int MAX_CL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              flush_i,
  input  logic [1:0]        cas_lat_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              oe_o
);
  logic              valid_q [MAX_CL];
  logic [DATA_W-1:0] data_q  [MAX_CL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q[0] <= 1'b0;
      data_q[0]  <= '0;
    end else begin
      valid_q[0] <= push_i;
      data_q[0]  <= data_i;
    end
  end

  for (genvar i = 1; i < MAX_CL; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        data_q[i]  <= '0;
      end else begin
        valid_q[i] <= valid_q[i-1] && !flush_i; // write turns the bus around at once
        data_q[i]  <= data_q[i-1];
      end
    end
  end

  int sel;
  always_comb begin
    if (int'(cas_lat_i) >= 2 && int'(cas_lat_i) <= MAX_CL) sel = int'(cas_lat_i) - 1;
    else sel = 1;
    dq_o = data_q[sel];
    oe_o = valid_q[sel];
  end

  assert_oe_traces_push_cl2_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && cas_lat_i == 2'd2 && $stable(cas_lat_i)) |-> $past(push_i, 2));
  assert_oe_traces_push_cl3_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && cas_lat_i == 2'd3 && $stable(cas_lat_i) && $past(cas_lat_i) == 2'd3)
      |-> $past(push_i, 3));
endmodule

// File: rtl/sdram_cell_array.sv
`timescale 1ns/1ps
module sdram_cell_array #(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 3,
  parameter int DATA_W = 8,
  localparam int IDX_W = ROW_W + COL_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx = {row_i, col_i};

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx] <= wdata_i;
  end

  assign rdata_o = mem_q[idx];

  logic              chk_vld_q;
  logic [IDX_W-1:0]  chk_idx_q;
  logic [DATA_W-1:0] chk_dat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_vld_q <= 1'b0;
      chk_idx_q <= '0;
      chk_dat_q <= '0;
    end else begin
      chk_vld_q <= we_i;
      chk_idx_q <= idx;
      chk_dat_q <= wdata_i;
    end
  end

  assert_write_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_vld_q |-> (mem_q[chk_idx_q] == chk_dat_q));
endmodule

// File: rtl/sdram_burst_term.sv
`timescale 1ns/1ps
module sdram_burst_term
  import sdram_bt_pkg::*;
#(
  parameter int ROW_W     = 2,
  parameter int COL_W     = 3,
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 4,
  parameter int MAX_CL    = 3,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [1:0]        cas_lat_i,
  input  logic              full_page_i,
  output logic              illegal_cmd_o
);
  cmd_e              cmd;
  logic              issue, issue_wr, wr_start;
  logic [COL_W-1:0]  issue_col;
  logic [ROW_W-1:0]  row;
  logic [DATA_W-1:0] rdata;

  sdram_cmd_decode u_dec (
    .cs_n_i (cs_n_i),
    .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i),
    .we_n_i (we_n_i),
    .cmd_o  (cmd)
  );

  sdram_burst_ctl #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .BURST_LEN(BURST_LEN)
  ) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .col_i      (addr_i[COL_W-1:0]),
    .row_i      (addr_i[ROW_W-1:0]),
    .full_page_i(full_page_i),
    .issue_o    (issue),
    .issue_wr_o (issue_wr),
    .issue_col_o(issue_col),
    .wr_start_o (wr_start),
    .row_o      (row),
    .illegal_o  (illegal_cmd_o)
  );

  sdram_cell_array #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W)
  ) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (issue && issue_wr),
    .row_i  (row),
    .col_i  (issue_col),
    .wdata_i(dq_i),
    .rdata_o(rdata)
  );

  sdram_read_pipe #(
    .DATA_W(DATA_W),
    .MAX_CL(MAX_CL)
  ) u_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (issue && !issue_wr),
    .data_i   (rdata),
    .flush_i  (wr_start),
    .cas_lat_i(cas_lat_i),
    .dq_o     (dq_o),
    .oe_o     (dq_oe_o)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk_i)
    !rst_ni |-> (!dq_oe_o && !illegal_cmd_o));
endmodule

// File: tb/sdram_burst_term_tb.sv
`timescale 1ns/1ps
module sdram_burst_term_tb;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_BST = 4'b0110;
  // {cas_lat[8:7], start col[6:4], beats before stop[3:0]}
  localparam logic [8:0] VEC [6] = '{9'b10_000_1000, 9'b11_000_0011, 9'b10_101_0110,
                                     9'b11_111_0010, 9'b10_011_0001, 9'b11_011_1010};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, cs_n, ras_n, cas_n, we_n, dq_oe, full_page, illegal;
  logic [2:0] addr;
  logic [7:0] dq_in, dq_out;
  logic [1:0] cas_lat;

  sdram_burst_term u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe),
    .cas_lat_i(cas_lat), .full_page_i(full_page), .illegal_cmd_o(illegal)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic       lg_oe  [4096];
  logic       lg_ill [4096];
  logic [7:0] lg_d   [4096];
  always @(negedge clk) begin
    lg_oe[cyc % 4096]  = dq_oe;
    lg_ill[cyc % 4096] = illegal;
    lg_d[cyc % 4096]   = dq_out;
  end

  int checks = 0, errors = 0, last_e = 0;
  bit done = 1'b0;
  logic [7:0] model [8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    addr   = a;
    dq_in  = d;
    last_e = cyc + 1;
  endtask

  task automatic idle(input int n);
    repeat (n) drive(C_NOP, 3'd0, 8'hEE);
  endtask

  // R2 R3 R4 R6: full-page read, stop after n beats
  task automatic read_stop(input int cl, input int col, input int n);
    int e;
    cas_lat = 2'(cl);
    drive(C_RD, 3'(col), 8'h00);
    e = last_e;
    idle(n - 1);
    drive(C_BST, 3'd0, 8'h00);
    idle(cl + 2);
    chk("R6 no illegal after stop", 32'(lg_ill[e % 4096]), 0);
    chk("R2 bus idle before beat 0", 32'(lg_oe[(e + cl - 2) % 4096]), 0);
    for (int k = 0; k < n; k++) begin
      chk("R2 beat valid", 32'(lg_oe[(e + cl - 1 + k) % 4096]), 1);
      chk("R3 beat data", 32'(lg_d[(e + cl - 1 + k) % 4096]), 32'(model[(col + k) % 8]));
    end
    chk("R4 bus off at stop+CL", 32'(lg_oe[(e + n + cl - 1) % 4096]), 0);
  endtask

  initial begin
    int e;
    rst_n = 1'b0; {cs_n, ras_n, cas_n, we_n} = C_NOP; addr = '0; dq_in = '0;
    cas_lat = 2'd2; full_page = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 reset oe", 32'(dq_oe), 0);
    chk("R11 reset illegal", 32'(illegal), 0);
    rst_n = 1'b1;
    idle(2);

    // R10 R11: no row open after reset
    drive(C_RD, 3'd0, 8'h00); e = last_e;
    idle(4);
    chk("R10 read without row flagged", 32'(lg_ill[e % 4096]), 1);
    chk("R10 flag one cycle", 32'(lg_ill[(e + 1) % 4096]), 0);
    chk("R10 no data driven", 32'(lg_oe[(e + 1) % 4096] | lg_oe[(e + 2) % 4096]), 0);

    drive(C_ACT, 3'd1, 8'h00);   // R1: open row 1
    // R5: fill page, stop-edge data 0xFF must be dropped
    drive(C_WR, 3'd0, 8'h10);
    for (int i = 1; i < 8; i++) drive(C_NOP, 3'd0, 8'(8'h10 + i));
    drive(C_BST, 3'd0, 8'hFF);
    for (int i = 0; i < 8; i++) model[i] = 8'(8'h10 + i);
    // R3 R5: wrapping write, columns 6,7,0,1,2; column 3 keeps 0x13
    drive(C_WR, 3'd6, 8'hA0);
    for (int i = 1; i < 5; i++) drive(C_NOP, 3'd0, 8'(8'hA0 + i));
    drive(C_BST, 3'd0, 8'hEE);
    idle(2);
    for (int i = 0; i < 5; i++) model[(6 + i) % 8] = 8'(8'hA0 + i);

    for (int v = 0; v < 6; v++)
      read_stop(int'(VEC[v][8:7]), int'(VEC[v][6:4]), int'(VEC[v][3:0]));

    // R7: stop in fixed mode is illegal, four beats still come out
    full_page = 1'b0; cas_lat = 2'd2;
    drive(C_RD, 3'd2, 8'h00); e = last_e;
    drive(C_BST, 3'd0, 8'h00);
    idle(6);
    chk("R7 illegal stop flagged", 32'(lg_ill[(e + 1) % 4096]), 1);
    chk("R7 flag one cycle", 32'(lg_ill[(e + 2) % 4096]), 0);
    for (int k = 0; k < 4; k++)
      chk("R7 fixed beat", 32'({lg_oe[(e + 1 + k) % 4096], lg_d[(e + 1 + k) % 4096]}),
          32'({1'b1, model[2 + k]}));
    chk("R7 fixed burst ends", 32'(lg_oe[(e + 5) % 4096]), 0);
    full_page = 1'b1;

    // R8: read interrupts read, CL 3
    cas_lat = 2'd3;
    drive(C_RD, 3'd0, 8'h00); e = last_e;
    drive(C_NOP, 3'd0, 8'h00);
    drive(C_RD, 3'd4, 8'h00);
    drive(C_NOP, 3'd0, 8'h00);
    drive(C_BST, 3'd0, 8'h00);
    idle(6);
    chk("R8 old beat 0", 32'({lg_oe[(e + 2) % 4096], lg_d[(e + 2) % 4096]}), 32'({1'b1, model[0]}));
    chk("R8 old beat 1", 32'({lg_oe[(e + 3) % 4096], lg_d[(e + 3) % 4096]}), 32'({1'b1, model[1]}));
    chk("R8 new beat 0", 32'({lg_oe[(e + 4) % 4096], lg_d[(e + 4) % 4096]}), 32'({1'b1, model[4]}));
    chk("R8 new beat 1", 32'({lg_oe[(e + 5) % 4096], lg_d[(e + 5) % 4096]}), 32'({1'b1, model[5]}));
    chk("R8 bus off", 32'(lg_oe[(e + 6) % 4096]), 0);

    // R9: precharge ends the burst and closes the row
    cas_lat = 2'd2;
    drive(C_RD, 3'd1, 8'h00); e = last_e;
    drive(C_NOP, 3'd0, 8'h00);
    drive(C_PRE, 3'd0, 8'h00);
    idle(4);
    chk("R9 beat 0", 32'({lg_oe[(e + 1) % 4096], lg_d[(e + 1) % 4096]}), 32'({1'b1, model[1]}));
    chk("R9 beat 1", 32'({lg_oe[(e + 2) % 4096], lg_d[(e + 2) % 4096]}), 32'({1'b1, model[2]}));
    chk("R9 bus off", 32'(lg_oe[(e + 3) % 4096]), 0);
    drive(C_RD, 3'd0, 8'h00); e = last_e;
    idle(3);
    chk("R9 row closed", 32'(lg_ill[e % 4096]), 1);
    chk("R9 no data after close", 32'(lg_oe[(e + 1) % 4096]), 0);

    // R10: write with no row must not store
    drive(C_WR, 3'd3, 8'h77); e = last_e;
    drive(C_NOP, 3'd0, 8'h78);
    drive(C_ACT, 3'd1, 8'h00);
    chk("R10 write without row flagged", 32'(lg_ill[e % 4096]), 1);
    read_stop(2, 3, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule